// File: doc/BRIEF.md
# Atomic Compare-and-Swap Execution Unit

This unit performs one compare-and-swap on a destination of 8, 16, 32 or 64 bits. On a start pulse it samples an accumulator value, a replacement value, a width code and two qualifiers: whether the destination is in memory or in a register, and whether the operation must be atomic. It then compares the accumulator against the destination.

On a match, the replacement value becomes the new destination contents. On a mismatch, the destination contents are copied into the accumulator. Either way the unit produces the full set of arithmetic status flags of the subtraction accumulator minus destination.

A memory destination always gets one read followed by one write. The write carries the unchanged old value when the comparison fails, so an atomic access never leaves a read without its write. When atomicity is requested, a lock-hold output stays asserted from the read through the write.

A register destination bypasses the memory port. Its value comes in on an input, and the value to store goes out on an output. Two faults end an operation early, before any access: an atomic request aimed at a register, and an optional natural-alignment check on memory addresses.

Top module: `cas_unit`

## Requirements
- R1: When the width-masked accumulator equals the width-masked destination, the unit reports ZF=1, `dst_out` equals `src_in` masked to the width, and `acc_out` equals `acc_in` unchanged.
- R2: On a mismatch, the unit reports ZF=0, `dst_out` equals the masked destination value, and `acc_out` takes the destination value in its low width bits while its upper bits keep those of `acc_in`.
- R3: A non-faulting operation on a memory destination makes exactly one read handshake followed by exactly one write handshake, never both in one cycle. The write data equals `dst_out`, so on a mismatch it is the value just read.
- R4: With `lock_req` set on a memory operation, `mem_lock` is high in every cycle from the read request through the cycle that completes the write, and low in the done cycle. Without `lock_req`, `mem_lock` stays low.
- R5: `flags_out` is packed as {OF,SF,ZF,AF,PF,CF} in bits 5 down to 0, computed from accumulator minus destination at the chosen width. CF is the borrow out of the width, AF is the borrow out of bit 3, SF is the top bit of the difference, and OF is signed overflow.
- R6: PF is 1 when the low 8 bits of the difference hold an even number of ones.
- R7: `size_sel` codes are 0=8, 1=16, 2=32 and 3=64 bits. Accumulator, destination and source bits above the width have no effect on the comparison, on the flags or on `dst_out`.
- R8: With `lock_req`=1 and `dst_is_mem`=0, the operation ends with `fault_ud`=1 and makes no memory access. `acc_out` equals `acc_in`, and `dst_out` and `flags_out` are zero.
- R9: When `align_chk_en`=1 on a memory operation and the address is not a multiple of the width in bytes, the operation ends with `fault_ac`=1. It makes no memory access, `acc_out` equals `acc_in`, and `dst_out` and `flags_out` are zero. With `align_chk_en`=0 the address alignment has no effect.
- R10: With `dst_is_mem`=0 the destination value is taken from `reg_dst_in`, and `mem_rd`, `mem_wr` and `mem_lock` stay low.
- R11: `done` is high for exactly one cycle per operation, and the results and fault bits are valid in that cycle. After reset `done`, `mem_rd`, `mem_wr` and `mem_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| size_sel | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| lock_req | input | 1 | Request an atomic (locked) access |
| dst_is_mem | input | 1 | 1: destination in memory, 0: in a register |
| align_chk_en | input | 1 | Enable the natural-alignment fault |
| addr | input | ADDR_W | Destination memory address |
| acc_in | input | DATA_W | Accumulator value |
| src_in | input | DATA_W | Replacement value |
| reg_dst_in | input | DATA_W | Register destination value |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_lock | output | 1 | Lock-hold across the read-modify-write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Completes the pending read or write |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| acc_out | output | DATA_W | Updated accumulator |
| dst_out | output | DATA_W | Value stored to the destination |
| flags_out | output | 6 | {OF,SF,ZF,AF,PF,CF} |
| fault_ud | output | 1 | Lock on a register destination (valid with done) |
| fault_ac | output | 1 | Misaligned memory access (valid with done) |

## Verification
The hardest case to reach is a locked mismatch whose memory handshakes are delayed. In that case the lock must span several stalled cycles, and the write must carry back exactly the value that was read. The memory model in the bench withholds `mem_ready` at random on every cycle, and an operation selects the matching case only when its destination is built as a copy of the accumulator. The stimulus therefore mixes deliberately equal operands, including copies with scrambled upper bits, with unrelated random ones. Directed operations cover signed overflow, borrow out of bit 3, every misalignment per width, and the fault paths.

// File: rtl/cas_pkg.sv
package cas_pkg;

   localparam int SIZE_W = 2;
   localparam int N_SIZES = 4;

   typedef enum logic [SIZE_W-1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } cas_size_e;

   typedef struct packed {
      logic of_f;
      logic sf_f;
      logic zf_f;
      logic af_f;
      logic pf_f;
      logic cf_f;
   } cas_flags_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_READ    = 3'd1,
      ST_COMPARE = 3'd2,
      ST_WRITE   = 3'd3,
      ST_DONE    = 3'd4
   } cas_state_e;

endpackage

// File: rtl/cas_align.sv
module cas_align
   import cas_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  cas_size_e         size,
   input  logic              chk_en,
   output logic              misaligned
);

   generate
      if (ENABLE) begin : g_chk
         logic [2:0] low;
         logic       hit;
         logic       unused_hi;
         assign low       = addr[2:0];
         assign unused_hi = ^addr[ADDR_W-1:3];
         always_comb begin
            unique case (size)
               SZ_B:    hit = 1'b0;
               SZ_H:    hit = low[0];
               SZ_W:    hit = |low[1:0];
               default: hit = |low;
            endcase
         end
         assign misaligned = chk_en & hit;
      end else begin : g_off
         logic unused_in;
         assign unused_in  = ^{addr, size, chk_en};
         assign misaligned = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cas_compare.sv
module cas_compare
   import cas_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] dest,
   input  logic [DATA_W-1:0] src,
   input  cas_size_e         size,
   output cas_flags_t        flags,
   output logic [DATA_W-1:0] acc_new,
   output logic [DATA_W-1:0] dst_new
);

   logic [N_SIZES-1:0][DATA_W-1:0] mask_tbl;
   logic [N_SIZES-1:0]             a_top;
   logic [N_SIZES-1:0]             d_top;
   logic [N_SIZES-1:0]             r_top;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] am;
   logic [DATA_W-1:0] dm;
   logic [DATA_W:0]   diff_ext;
   logic [DATA_W-1:0] rm;
   logic              eq;

   assign mask     = mask_tbl[size];
   assign am       = acc & mask;
   assign dm       = dest & mask;
   assign diff_ext = {1'b0, am} - {1'b0, dm};
   assign rm       = diff_ext[DATA_W-1:0] & mask;
   assign eq       = (am == dm);

   generate
      for (genvar i = 0; i < N_SIZES; i++) begin : g_width
         localparam int W = 8 << i;
         if (W >= DATA_W) begin : g_full
            assign mask_tbl[i] = '1;
         end else begin : g_part
            assign mask_tbl[i] = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
         end
         assign a_top[i] = am[W-1];
         assign d_top[i] = dm[W-1];
         assign r_top[i] = rm[W-1];
      end
   endgenerate

   always_comb begin
      flags.cf_f = diff_ext[DATA_W];
      flags.zf_f = eq;
      flags.af_f = am[4] ^ dm[4] ^ rm[4];
      flags.pf_f = ~^rm[7:0];
      flags.sf_f = r_top[size];
      flags.of_f = (a_top[size] ^ d_top[size]) & (a_top[size] ^ r_top[size]);
   end

   assign acc_new = eq ? acc : ((acc & ~mask) | dm);
   assign dst_new = eq ? (src & mask) : dm;

endmodule

// File: rtl/cas_unit.sv
module cas_unit
   import cas_pkg::*;
#(
   parameter int DATA_W         = 64,
   parameter int ADDR_W         = 32,
   parameter bit ALIGN_FAULT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        size_sel,
   input  logic              lock_req,
   input  logic              dst_is_mem,
   input  logic              align_chk_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic [DATA_W-1:0] reg_dst_in,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done,
   output logic              busy,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] dst_out,
   output logic [5:0]        flags_out,
   output logic              fault_ud,
   output logic              fault_ac
);

   localparam int FLAG_W = $bits(cas_flags_t);

   generate
      if (DATA_W != 64) begin : g_bad_data_w
         $fatal(1, "cas_unit: DATA_W must be 64 to hold the widest operand");
      end
      if (ADDR_W < 3) begin : g_bad_addr_w
         $fatal(1, "cas_unit: ADDR_W must cover the 8-byte alignment bits");
      end
      if (FLAG_W != 6) begin : g_bad_flag_w
         $fatal(1, "cas_unit: flag record must be six bits");
      end
   endgenerate

   cas_state_e        state_q;
   cas_size_e         size_q;
   logic              lock_q;
   logic              is_mem_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] dest_q;
   logic [DATA_W-1:0] acc_res_q;
   logic [DATA_W-1:0] dst_res_q;
   cas_flags_t        flags_res_q;
   logic              ud_q;
   logic              ac_q;

   cas_size_e         size_in;
   logic              misaligned;
   logic              ud_hit;
   cas_flags_t        cmp_flags;
   logic [DATA_W-1:0] cmp_acc;
   logic [DATA_W-1:0] cmp_dst;

   assign size_in = cas_size_e'(size_sel);
   assign ud_hit  = lock_req & ~dst_is_mem;

   cas_align #(
      .ADDR_W (ADDR_W),
      .ENABLE (ALIGN_FAULT_EN)
   ) u_align (
      .addr       (addr),
      .size       (size_in),
      .chk_en     (align_chk_en & dst_is_mem),
      .misaligned (misaligned)
   );

   cas_compare #(
      .DATA_W (DATA_W)
   ) u_cmp (
      .acc     (acc_q),
      .dest    (dest_q),
      .src     (src_q),
      .size    (size_q),
      .flags   (cmp_flags),
      .acc_new (cmp_acc),
      .dst_new (cmp_dst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         size_q      <= SZ_B;
         lock_q      <= 1'b0;
         is_mem_q    <= 1'b0;
         addr_q      <= '0;
         acc_q       <= '0;
         src_q       <= '0;
         dest_q      <= '0;
         acc_res_q   <= '0;
         dst_res_q   <= '0;
         flags_res_q <= '0;
         ud_q        <= 1'b0;
         ac_q        <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  size_q      <= size_in;
                  lock_q      <= lock_req;
                  is_mem_q    <= dst_is_mem;
                  addr_q      <= addr;
                  acc_q       <= acc_in;
                  src_q       <= src_in;
                  dest_q      <= reg_dst_in;
                  ud_q        <= ud_hit;
                  ac_q        <= ~ud_hit & misaligned;
                  acc_res_q   <= acc_in;
                  dst_res_q   <= '0;
                  flags_res_q <= '0;
                  if (ud_hit || misaligned) begin
                     state_q <= ST_DONE;
                  end else if (dst_is_mem) begin
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_COMPARE;
                  end
               end
            end
            ST_READ: begin
               if (mem_ready) begin
                  dest_q  <= mem_rdata;
                  state_q <= ST_COMPARE;
               end
            end
            ST_COMPARE: begin
               acc_res_q   <= cmp_acc;
               dst_res_q   <= cmp_dst;
               flags_res_q <= cmp_flags;
               state_q     <= is_mem_q ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: begin
               if (mem_ready) begin
                  state_q <= ST_DONE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_rd    = (state_q == ST_READ);
   assign mem_wr    = (state_q == ST_WRITE);
   assign mem_lock  = lock_q & ((state_q == ST_READ) ||
                                (state_q == ST_COMPARE) ||
                                (state_q == ST_WRITE));
   assign mem_addr  = addr_q;
   assign mem_wdata = dst_res_q;

   assign done      = (state_q == ST_DONE);
   assign busy      = (state_q != ST_IDLE);
   assign acc_out   = acc_res_q;
   assign dst_out   = dst_res_q;
   assign flags_out = flags_res_q;
   assign fault_ud  = done & ud_q;
   assign fault_ac  = done & ac_q;

endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_rd,
   input logic mem_wr,
   input logic mem_lock,
   input logic mem_ready,
   input logic done,
   input logic fault_ud,
   input logic fault_ac
);

   logic rd_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pending <= 1'b0;
      end else if (mem_rd && mem_ready) begin
         rd_pending <= 1'b1;
      end else if (mem_wr && mem_ready) begin
         rd_pending <= 1'b0;
      end
   end

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R3

   AST_WR_PAIRS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_pending); // R3

   AST_LOCK_HELD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_lock) |-> $past(mem_wr && mem_ready)); // R4

   AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ud || fault_ac) |-> $past(!mem_rd && !mem_wr)); // R8

   AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ud || fault_ac) |-> (done && !(fault_ud && fault_ac))); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

endmodule

bind cas_unit cas_unit_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_lock  (mem_lock),
   .mem_ready (mem_ready),
   .done      (done),
   .fault_ud  (fault_ud),
   .fault_ac  (fault_ac)
);

// File: tb/tb_cas_unit.sv
module tb_cas_unit;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    size_sel = '0;
   logic          lock_req = 1'b0;
   logic          dst_is_mem = 1'b0;
   logic          align_chk_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] acc_in = '0;
   logic [DW-1:0] src_in = '0;
   logic [DW-1:0] reg_dst_in = '0;
   logic          mem_rd, mem_wr, mem_lock;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ready = 1'b0;
   logic          done, busy;
   logic [DW-1:0] acc_out, dst_out;
   logic [5:0]    flags_out;
   logic          fault_ud, fault_ac;

   int n_tests = 0;
   int n_fail  = 0;

   logic [DW-1:0] mem_word = '0;
   logic [DW-1:0] wr_seen_data = '0;
   int            rd_cnt = 0;
   int            wr_cnt = 0;
   bit            exp_lock = 1'b0;
   bit            lock_bad = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cas_unit dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .size_sel     (size_sel),
      .lock_req     (lock_req),
      .dst_is_mem   (dst_is_mem),
      .align_chk_en (align_chk_en),
      .addr         (addr),
      .acc_in       (acc_in),
      .src_in       (src_in),
      .reg_dst_in   (reg_dst_in),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .mem_lock     (mem_lock),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_rdata    (mem_rdata),
      .mem_ready    (mem_ready),
      .done         (done),
      .busy         (busy),
      .acc_out      (acc_out),
      .dst_out      (dst_out),
      .flags_out    (flags_out),
      .fault_ud     (fault_ud),
      .fault_ac     (fault_ac)
   );

   // Memory model: decides ready on the falling edge; a handshake logged here
   // completes at the following rising edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_cnt > 0 && wr_cnt == 0 && exp_lock && !mem_lock) lock_bad = 1'b1;
         if (!exp_lock && mem_lock) lock_bad = 1'b1;
         mem_ready = (mem_rd || mem_wr) && ($urandom_range(0, 2) != 0);
         if (mem_ready && mem_rd) begin
            mem_rdata = mem_word;
            rd_cnt++;
            if (exp_lock && !mem_lock) lock_bad = 1'b1;
         end
         if (mem_ready && mem_wr) begin
            wr_seen_data = mem_wdata;
            wr_cnt++;
            if (exp_lock && !mem_lock) lock_bad = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] sz, input logic [DW-1:0] acc,
                                 input logic [DW-1:0] src, input logic [DW-1:0] dst,
                                 output logic [DW-1:0] e_acc, output logic [DW-1:0] e_dst,
                                 output logic [5:0] e_flags);
      int            w;
      logic [DW-1:0] m, a, d, r;
      bit            zf, cf, af, sf, of, pf, sa, sd, sr;
      w  = 8 << sz;
      m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      a  = acc & m;
      d  = dst & m;
      r  = (a - d) & m;
      zf = (a == d);
      cf = (a < d);
      af = (a[3:0] < d[3:0]);
      sa = a[w-1];
      sd = d[w-1];
      sr = r[w-1];
      sf = sr;
      of = (sa != sd) && (sr != sa);
      pf = ($countones(r[7:0]) % 2) == 0;
      e_flags = {of, sf, zf, af, pf, cf};
      e_acc   = zf ? acc : ((acc & ~m) | d);
      e_dst   = zf ? (src & m) : d;
   endfunction

   task automatic run_op(input logic [1:0] sz, input bit lk, input bit mem, input bit achk,
                         input logic [AW-1:0] ad, input logic [DW-1:0] acc,
                         input logic [DW-1:0] src, input logic [DW-1:0] dv,
                         input string tag);
      logic [DW-1:0] e_acc, e_dst;
      logic [5:0]    e_flags;
      bit            e_ud, e_ac, got_done;
      int            bytes;
      bytes = 1 << sz;
      e_ud  = lk && !mem;
      e_ac  = !e_ud && mem && achk && ((ad & (bytes - 1)) != 0);
      model(sz, acc, src, dv, e_acc, e_dst, e_flags);
      if (e_ud || e_ac) begin
         e_acc   = acc;
         e_dst   = '0;
         e_flags = '0;
      end
      @(negedge clk);
      mem_word     = dv;
      rd_cnt       = 0;
      wr_cnt       = 0;
      lock_bad     = 1'b0;
      exp_lock     = lk && mem && !e_ud && !e_ac;
      size_sel     = sz;
      lock_req     = lk;
      dst_is_mem   = mem;
      align_chk_en = achk;
      addr         = ad;
      acc_in       = acc;
      src_in       = src;
      reg_dst_in   = dv;
      start        = 1'b1;
      got_done     = 1'b0;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         start = 1'b0;
         if (done) begin
            got_done = 1'b1;
            break;
         end
      end
      check(got_done, {"R11 done seen (watchdog) ", tag}, 64'(got_done), 64'd1);
      if (!got_done) return;
      check(fault_ud == e_ud, {"R8 fault_ud ", tag}, 64'(fault_ud), 64'(e_ud));
      check(fault_ac == e_ac, {"R9 fault_ac ", tag}, 64'(fault_ac), 64'(e_ac));
      check(acc_out == e_acc, {(e_flags[3] ? "R1" : "R2"), " acc_out ", tag}, acc_out, e_acc);
      check(dst_out == e_dst, {(e_flags[3] ? "R1" : "R2"), " dst_out ", tag}, dst_out, e_dst);
      check(flags_out[5:1] == e_flags[5:1] && flags_out[0] == e_flags[0],
            {"R5 flags ", tag}, 64'(flags_out), 64'(e_flags));
      check(flags_out[1] == e_flags[1], {"R6 parity ", tag}, 64'(flags_out[1]), 64'(e_flags[1]));
      if (e_ud || e_ac || !mem) begin
         check(rd_cnt == 0 && wr_cnt == 0, {"R10 no memory access ", tag},
               64'(rd_cnt + wr_cnt), 64'd0);
      end else begin
         check(rd_cnt == 1 && wr_cnt == 1, {"R3 one read one write ", tag},
               64'(rd_cnt * 16 + wr_cnt), 64'h11);
         check(wr_seen_data == e_dst, {"R3 write data ", tag}, wr_seen_data, e_dst);
      end
      check(!lock_bad && !mem_lock, {"R4 lock span ", tag}, 64'(lock_bad), 64'd0);
      @(negedge clk);
      check(!done, {"R11 done one cycle ", tag}, 64'(done), 64'd0);
      exp_lock = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 global watchdog expired: actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check(!done && !mem_rd && !mem_wr && !mem_lock, "R11 reset state",
            64'({done, mem_rd, mem_wr, mem_lock}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: upper bits differ but low byte matches
      run_op(2'd0, 1'b0, 1'b1, 1'b1, 32'h13, 64'hAAAA_0000_0000_0042,
             64'hFFFF_FFFF_FFFF_FF99, 64'h5555_0000_0000_0042, "R7 byte match");
      run_op(2'd1, 1'b1, 1'b1, 1'b1, 32'h10, 64'hDEAD_BEEF_0000_1234,
             64'h0, 64'h1111_2222_3333_1235, "R2 half mismatch locked");
      run_op(2'd2, 1'b1, 1'b1, 1'b0, 32'h20, 64'h0000_0000_8000_0000,
             64'h7, 64'h0000_0000_0000_0001, "R5 word signed overflow");
      run_op(2'd3, 1'b0, 1'b1, 1'b1, 32'h40, 64'h0,
             64'h1, 64'h1, "R5 dword borrow");
      run_op(2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 64'h10,
             64'h0, 64'h01, "R5 aux borrow register");
      run_op(2'd3, 1'b1, 1'b1, 1'b1, 32'h80, 64'h0123_4567_89AB_CDEF,
             64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, "R4 locked dword match");
      run_op(2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 64'h5, 64'h6, 64'h5, "R8 lock on register");
      run_op(2'd2, 1'b0, 1'b1, 1'b1, 32'h22, 64'h5, 64'h6, 64'h5, "R9 word misaligned");
      run_op(2'd3, 1'b1, 1'b1, 1'b1, 32'h44, 64'h5, 64'h6, 64'h5, "R9 dword misaligned");
      run_op(2'd1, 1'b0, 1'b1, 1'b1, 32'h31, 64'h5, 64'h6, 64'h5, "R9 half misaligned");
      run_op(2'd0, 1'b0, 1'b1, 1'b1, 32'h37, 64'h5, 64'h6, 64'h5, "R9 byte any address");
      run_op(2'd3, 1'b0, 1'b1, 1'b0, 32'h45, 64'h9, 64'h6, 64'h5, "R9 check disabled");
      run_op(2'd1, 1'b0, 1'b0, 1'b1, 32'h33, 64'hFFFF_0000_0000_ABCD,
             64'h1234, 64'h0000_0000_0000_ABCD, "R10 register match");

      for (int i = 0; i < 400; i++) begin
         logic [DW-1:0] a, s, d;
         logic [1:0]    sz;
         bit            lk, mem, achk;
         sz   = 2'($urandom_range(0, 3));
         lk   = 1'($urandom_range(0, 1));
         mem  = ($urandom_range(0, 7) != 0);
         achk = 1'($urandom_range(0, 1));
         a    = {$urandom, $urandom};
         s    = {$urandom, $urandom};
         case ($urandom_range(0, 2))
            0:       d = a;
            1:       d = a ^ {$urandom, 32'h0} ^ 64'h0000_0000_FF00_0000;
            default: d = {$urandom, $urandom};
         endcase
         run_op(sz, lk, mem, achk, $urandom & 32'hFFFF_FFF8 | 32'($urandom_range(0, 7) == 0 ?
                $urandom_range(1, 7) : 0), a, s, d, "R7 random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule